// File: doc/BRIEF.md
# Instruction fetch with wide-immediate merge

This block walks a program memory one 64-bit slot at a time and turns each slot into a decoded bundle for the execution stage. A bundle carries the opcode, the destination and source register numbers, the signed offset, a 64-bit immediate, and the access size and addressing mode of load/store-class opcodes. One opcode (0x18) is twice as long as the others. It takes two consecutive slots, and the block joins their immediates into a single 64-bit constant, so the execution stage always receives exactly one bundle per instruction.

Fetch begins at slot 0 when reset is released and moves forward in program order. The memory port has a combinational read: the address comes from the program counter and the slot word is returned in the same cycle. Bundles leave through a valid/ready handshake. If the block finds a malformed instruction, or if the counter runs past the last slot, it raises a sticky illegal flag and stops fetching until the next reset. Executing the instructions is left to later stages.

Top module: `insn_fetch_unit`

## Requirements
- R1: Slot word fields are opcode [7:0], dst [11:8], src [15:12], off [31:16], imm [63:32]. For every opcode except 0x18, the bundle immediate is imm sign-extended to 64 bits.
- R2: Opcode 0x18 produces one bundle. Its opcode, dst, src and off come from the first slot. Its immediate has bits [31:0] from the first slot's imm and bits [63:32] from the following slot's imm.
- R3: If the slot after an 0x18 slot has a nonzero opcode, the illegal flag is raised and no bundle is produced for the pair.
- R4: Bundles are delivered in program order with none skipped or repeated. After an 0x18 instruction the next bundle comes from the slot two past it; after any other instruction it comes from the next slot.
- R5: For load/store classes (opcode[2:0] below 4), out_size_log2 is 2, 1, 0 or 3 when opcode[4:3] is 0, 1, 2 or 3, and out_mode is opcode[7:5]. For all other classes both outputs are 0.
- R6: A load/store-class opcode with opcode[7:5] equal to 4 or 5 raises the illegal flag. The same bit values in any other class have no effect, and that instruction is delivered normally.
- R7: An 0x18 opcode in the last slot (PROG_SLOTS-1) raises the illegal flag.
- R8: When the program counter reaches PROG_SLOTS, the illegal flag is raised.
- R9: The illegal flag rises only after every earlier bundle has been accepted. It then stays high until reset, out_valid stays low, and mem_addr no longer changes.
- R10: While out_valid is high and out_ready is low, out_valid and every bundle output hold their values.
- R11: During reset, out_valid is 0, illegal is 0 and mem_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | $clog2(PROG_SLOTS) | Slot index read from program memory |
| mem_rdata | input | 64 | Slot word at mem_addr, same cycle |
| out_valid | output | 1 | Bundle available |
| out_ready | input | 1 | Execution stage accepts the bundle |
| out_opcode | output | 8 | Opcode |
| out_dst | output | 4 | Destination register number |
| out_src | output | 4 | Source register number |
| out_off | output | 16 | Signed offset |
| out_imm | output | 64 | Immediate, sign-extended or merged |
| out_size_log2 | output | 2 | log2 of the access size in bytes |
| out_mode | output | 3 | Addressing mode of load/store classes |
| illegal | output | 1 | Sticky illegal-instruction flag |

## Verification
Two events can fall in the same clock edge: the consumer accepts the last good bundle, and the fetch logic detects the fault that ends the program. The bench provokes this with programs that end in a reserved mode, in a broken pair, in a wide opcode in the last slot, or by running past the end. It drives ready with several stall patterns, so the fault sometimes waits behind a held bundle and sometimes coincides with the acceptance. When illegal is first seen, the behavioural model's queue of expected bundles must be empty. On every clock, a stalled bundle must match the one seen on the previous clock.

// File: rtl/ifu_pkg.sv
// Shared definitions for the instruction fetch unit.
// Assumes 64-bit slots with the opcode in the low byte.
package ifu_pkg;

    localparam int SLOT_W = 64;
    localparam logic [7:0] WIDE_LOAD_OP = 8'h18;
    localparam logic [2:0] MODE_RSV_LO  = 3'd4;
    localparam logic [2:0] MODE_RSV_HI  = 3'd5;

    typedef struct packed {
        logic [7:0]  opcode;
        logic [3:0]  dst;
        logic [3:0]  src;
        logic [15:0] off;
        logic [63:0] imm;
        logic [1:0]  size_log2;
        logic [2:0]  mode;
    } ifu_bundle_t;

    // Map the two-bit size field to log2 of the byte count.
    function automatic logic [1:0] size_field_to_log2(input logic [1:0] f);
        case (f)
            2'd0:    return 2'd2;
            2'd1:    return 2'd1;
            2'd2:    return 2'd0;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/ifu_slot_split.sv
// Splits one raw program slot into its fields and classifies it.
// Purely combinational. Assumes the slot word is valid whenever it is used.
module ifu_slot_split
    import ifu_pkg::*;
(
    input  logic [SLOT_W-1:0] slot_word,
    output logic [7:0]        opcode,
    output logic [3:0]        dst,
    output logic [3:0]        src,
    output logic [15:0]       off,
    output logic [31:0]       imm32,
    output logic              is_wide,
    output logic              mode_reserved,
    output logic [1:0]        size_log2,
    output logic [2:0]        mode
);

    logic is_mem_class;

    // Field extraction at fixed bit positions.
    assign opcode = slot_word[7:0];
    assign dst    = slot_word[11:8];
    assign src    = slot_word[15:12];
    assign off    = slot_word[31:16];
    assign imm32  = slot_word[63:32];

    // Load/store classes have class bit 2 clear.
    assign is_mem_class = ~opcode[2];
    assign is_wide      = (opcode == WIDE_LOAD_OP);

    // Size and mode are meaningful only for load/store classes.
    always_comb begin
        if (is_mem_class) begin
            size_log2 = size_field_to_log2(opcode[4:3]);
            mode      = opcode[7:5];
        end else begin
            size_log2 = 2'd0;
            mode      = 3'd0;
        end
    end

    assign mode_reserved = is_mem_class &&
                           (opcode[7:5] == MODE_RSV_LO || opcode[7:5] == MODE_RSV_HI);

endmodule

// File: rtl/ifu_fetch_ctl.sv
// Program counter, pairing of wide slots, and fault detection.
// Handles one slot per cycle while the output register can take a bundle.
// Assumes mem_rdata reflects pc in the same cycle.
module ifu_fetch_ctl
    import ifu_pkg::*;
#(
    parameter int PROG_SLOTS = 4096,
    parameter int PC_W       = $clog2(PROG_SLOTS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              can_load,
    input  logic [7:0]        opcode,
    input  logic [3:0]        dst,
    input  logic [3:0]        src,
    input  logic [15:0]       off,
    input  logic [31:0]       imm32,
    input  logic              is_wide,
    input  logic              mode_reserved,
    input  logic [1:0]        size_log2,
    input  logic [2:0]        mode,
    output logic [PC_W-1:0]   pc,
    output logic              load_en,
    output ifu_bundle_t       bundle,
    output logic              halted
);

    localparam logic [PC_W-1:0] LAST_PC = PC_W'(PROG_SLOTS - 1);
    localparam logic [PC_W-1:0] END_PC  = PC_W'(PROG_SLOTS);

    typedef enum logic [1:0] {ACT_WAIT, ACT_EMIT, ACT_PAIR, ACT_FAULT} act_t;

    act_t        act;
    logic        second;
    logic [7:0]  hold_op;
    logic [3:0]  hold_dst;
    logic [3:0]  hold_src;
    logic [15:0] hold_off;
    logic [31:0] hold_lo;

    // Choose this cycle's action from the phase and the slot contents.
    always_comb begin
        act = ACT_WAIT;
        if (!halted && can_load) begin
            if (!second) begin
                if (pc >= END_PC)        act = ACT_FAULT;
                else if (is_wide)        act = (pc == LAST_PC) ? ACT_FAULT : ACT_PAIR;
                else if (mode_reserved)  act = ACT_FAULT;
                else                     act = ACT_EMIT;
            end else begin
                act = (opcode == 8'h00) ? ACT_EMIT : ACT_FAULT;
            end
        end
    end

    // Build the bundle, either from one slot or from the held half plus this slot.
    always_comb begin
        if (second) begin
            bundle.opcode    = hold_op;
            bundle.dst       = hold_dst;
            bundle.src       = hold_src;
            bundle.off       = hold_off;
            bundle.imm       = {imm32, hold_lo};
            bundle.size_log2 = 2'd3;
            bundle.mode      = 3'd0;
        end else begin
            bundle.opcode    = opcode;
            bundle.dst       = dst;
            bundle.src       = src;
            bundle.off       = off;
            bundle.imm       = {{32{imm32[31]}}, imm32};
            bundle.size_log2 = size_log2;
            bundle.mode      = mode;
        end
    end

    assign load_en = (act == ACT_EMIT);

    // Advance the counter, track the pair phase, and latch the fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            second   <= 1'b0;
            halted   <= 1'b0;
            hold_op  <= '0;
            hold_dst <= '0;
            hold_src <= '0;
            hold_off <= '0;
            hold_lo  <= '0;
        end else begin
            case (act)
                ACT_EMIT: begin
                    pc     <= pc + 1'b1;
                    second <= 1'b0;
                end
                ACT_PAIR: begin
                    pc       <= pc + 1'b1;
                    second   <= 1'b1;
                    hold_op  <= opcode;
                    hold_dst <= dst;
                    hold_src <= src;
                    hold_off <= off;
                    hold_lo  <= imm32;
                end
                ACT_FAULT: halted <= 1'b1;
                default: ;
            endcase
        end
    end

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R4
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> (pc == $past(pc) || pc == $past(pc) + 1'b1));

    // R7
    pair_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        second |-> (pc < END_PC));

endmodule

// File: rtl/ifu_bundle_reg.sv
// Output register of the valid/ready handshake toward execution.
// Holds the bundle while the consumer stalls. Assumes load_en is raised
// only when can_load is high.
module ifu_bundle_reg
    import ifu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_en,
    input  ifu_bundle_t bundle_in,
    input  logic        out_ready,
    output logic        out_valid,
    output ifu_bundle_t bundle_q,
    output logic        can_load
);

    assign can_load = !out_valid || out_ready;

    // Load a new bundle, or drop valid once the held one is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            bundle_q  <= '0;
        end else if (load_en) begin
            out_valid <= 1'b1;
            bundle_q  <= bundle_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(bundle_q)));

endmodule

// File: rtl/insn_fetch_unit.sv
// Instruction fetch with wide-immediate merge.
// Reads one slot per cycle, joins the two slots of the wide load, and
// presents decoded bundles through valid/ready. Stops on a fault.
// Assumes a program memory with a combinational read.
module insn_fetch_unit
    import ifu_pkg::*;
#(
    parameter int PROG_SLOTS = 4096,
    localparam int ADDR_W    = $clog2(PROG_SLOTS),
    localparam int PC_W      = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [63:0]       mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_opcode,
    output logic [3:0]        out_dst,
    output logic [3:0]        out_src,
    output logic [15:0]       out_off,
    output logic [63:0]       out_imm,
    output logic [1:0]        out_size_log2,
    output logic [2:0]        out_mode,
    output logic              illegal
);

    logic [7:0]  s_opcode;
    logic [3:0]  s_dst;
    logic [3:0]  s_src;
    logic [15:0] s_off;
    logic [31:0] s_imm32;
    logic        s_wide;
    logic        s_rsv;
    logic [1:0]  s_size;
    logic [2:0]  s_mode;

    logic [PC_W-1:0] pc;
    logic            load_en;
    logic            can_load;
    ifu_bundle_t     next_bundle;
    ifu_bundle_t     held_bundle;

    ifu_slot_split u_split (
        .slot_word     (mem_rdata),
        .opcode        (s_opcode),
        .dst           (s_dst),
        .src           (s_src),
        .off           (s_off),
        .imm32         (s_imm32),
        .is_wide       (s_wide),
        .mode_reserved (s_rsv),
        .size_log2     (s_size),
        .mode          (s_mode)
    );

    ifu_fetch_ctl #(.PROG_SLOTS(PROG_SLOTS), .PC_W(PC_W)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .can_load      (can_load),
        .opcode        (s_opcode),
        .dst           (s_dst),
        .src           (s_src),
        .off           (s_off),
        .imm32         (s_imm32),
        .is_wide       (s_wide),
        .mode_reserved (s_rsv),
        .size_log2     (s_size),
        .mode          (s_mode),
        .pc            (pc),
        .load_en       (load_en),
        .bundle        (next_bundle),
        .halted        (illegal)
    );

    ifu_bundle_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .bundle_in (next_bundle),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .bundle_q  (held_bundle),
        .can_load  (can_load)
    );

    // Memory address is the counter truncated to the slot index width.
    assign mem_addr      = pc[ADDR_W-1:0];
    assign out_opcode    = held_bundle.opcode;
    assign out_dst       = held_bundle.dst;
    assign out_src       = held_bundle.src;
    assign out_off       = held_bundle.off;
    assign out_imm       = held_bundle.imm;
    assign out_size_log2 = held_bundle.size_log2;
    assign out_mode      = held_bundle.mode;

    // R9
    valid_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !out_valid);

    // R6
    reserved_mode_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_opcode[2]) |-> (out_mode != 3'd4 && out_mode != 3'd5));

endmodule

// File: tb/insn_fetch_unit_tb.sv
// Bench: a behavioural walk of each program builds a queue of expected
// bundles, and the outputs are compared against it on every clock.
module insn_fetch_unit_tb_top;

    localparam int N  = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_rdata;
    logic          out_valid;
    logic          out_ready;
    logic [7:0]    out_opcode;
    logic [3:0]    out_dst;
    logic [3:0]    out_src;
    logic [15:0]   out_off;
    logic [63:0]   out_imm;
    logic [1:0]    out_size_log2;
    logic [2:0]    out_mode;
    logic          illegal;

    logic [63:0] prog [N];

    always #5 clk = ~clk;

    assign mem_rdata = prog[mem_addr];

    insn_fetch_unit #(.PROG_SLOTS(N)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mem_addr      (mem_addr),
        .mem_rdata     (mem_rdata),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_opcode    (out_opcode),
        .out_dst       (out_dst),
        .out_src       (out_src),
        .out_off       (out_off),
        .out_imm       (out_imm),
        .out_size_log2 (out_size_log2),
        .out_mode      (out_mode),
        .illegal       (illegal)
    );

    typedef struct {
        logic [7:0]  op;
        logic [3:0]  dst;
        logic [3:0]  src;
        logic [15:0] off;
        logic [63:0] imm;
        logic [1:0]  sz;
        logic [2:0]  md;
        bit          wide;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   errors = 0;

    function automatic logic [63:0] mk(input logic [7:0] op, input logic [3:0] d,
                                       input logic [3:0] s, input logic [15:0] o,
                                       input logic [31:0] i);
        return {i, o, s, d, op};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic exp_t expect_of(input logic [63:0] w, input logic [63:0] w2, input bit wide);
        exp_t e;
        e.op   = w[7:0];
        e.dst  = w[11:8];
        e.src  = w[15:12];
        e.off  = w[31:16];
        e.wide = wide;
        if (wide) e.imm = {w2[63:32], w[63:32]};
        else      e.imm = {{32{w[63]}}, w[63:32]};
        if (w[2] == 1'b0) begin
            case (w[4:3])
                2'd0: e.sz = 2'd2;
                2'd1: e.sz = 2'd1;
                2'd2: e.sz = 2'd0;
                default: e.sz = 2'd3;
            endcase
            e.md = w[7:5];
        end else begin
            e.sz = 2'd0;
            e.md = 3'd0;
        end
        return e;
    endfunction

    // Walk the program as the requirements describe it.
    task automatic build_expect();
        int pc = 0;
        bit done = 0;
        expq.delete();
        while (!done) begin
            if (pc >= N) done = 1;
            else if (prog[pc][7:0] == 8'h18) begin
                if (pc == N - 1 || prog[pc+1][7:0] != 8'h00) done = 1;
                else begin
                    expq.push_back(expect_of(prog[pc], prog[pc+1], 1'b1));
                    pc += 2;
                end
            end else if (prog[pc][2] == 1'b0 &&
                         (prog[pc][7:5] == 3'd4 || prog[pc][7:5] == 3'd5)) done = 1;
            else begin
                expq.push_back(expect_of(prog[pc], 64'd0, 1'b0));
                pc += 1;
            end
        end
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R11", "valid in reset", out_valid, 0);
        check(illegal == 1'b0, "R11", "illegal in reset", illegal, 0);
        check(mem_addr == '0, "R11", "addr in reset", mem_addr, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_test(input int ready_mode, input string end_tag);
        int delivered = 0;
        int total;
        int cyc = 0;
        bit stall = 0;
        bit fin = 0;
        logic [100:0] snap = '0;
        logic [100:0] now_b;
        logic [AW-1:0] addr_at_halt;
        string tag;
        exp_t e;
        build_expect();
        total = expq.size();
        while (!fin) begin
            @(negedge clk);
            case (ready_mode)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 3) != 1;
                default: out_ready = (cyc % 7) >= 4;
            endcase
            #1;
            now_b = {out_opcode, out_dst, out_src, out_off, out_imm, out_size_log2, out_mode};
            if (stall) begin
                check(out_valid == 1'b1, "R10", "valid held", out_valid, 1);
                check(now_b == snap, "R10", "bundle held", now_b, snap);
            end
            if (illegal) begin
                check(expq.size() == 0, end_tag, "bundles pending at fault", expq.size(), 0);
                check(delivered == total, "R4", "delivered count", delivered, total);
                check(out_valid == 1'b0, "R9", "valid at fault", out_valid, 0);
                addr_at_halt = mem_addr;
                repeat (4) begin
                    @(negedge clk);
                    #1;
                    check(illegal == 1'b1, "R9", "flag sticky", illegal, 1);
                    check(out_valid == 1'b0, "R9", "valid stays low", out_valid, 0);
                    check(mem_addr == addr_at_halt, "R9", "fetch stopped", mem_addr, addr_at_halt);
                end
                fin = 1;
            end else begin
                if (out_valid && out_ready) begin
                    if (expq.size() == 0) begin
                        check(0, "R4", "unexpected bundle", out_opcode, 0);
                    end else begin
                        e = expq.pop_front();
                        if (e.wide) tag = "R2";
                        else if (e.op[2] && (e.op[7:5] == 3'd4 || e.op[7:5] == 3'd5)) tag = "R6";
                        else tag = "R1";
                        check(out_opcode == e.op, "R4", "opcode order", out_opcode, e.op);
                        check(out_dst == e.dst && out_src == e.src, tag, "regs",
                              {out_dst, out_src}, {e.dst, e.src});
                        check(out_off == e.off, tag, "offset", out_off, e.off);
                        check(out_imm == e.imm, tag, "immediate", out_imm, e.imm);
                        check(out_size_log2 == e.sz, "R5", "size", out_size_log2, e.sz);
                        check(out_mode == e.md, "R5", "mode", out_mode, e.md);
                        delivered++;
                    end
                end
                stall = out_valid && !out_ready;
                snap  = now_b;
                cyc++;
                if (cyc > 600) begin
                    check(0, "WATCHDOG", "no fault seen", cyc, 600);
                    fin = 1;
                end
            end
        end
    endtask

    task automatic fill_plain();
        for (int i = 0; i < N; i++) prog[i] = mk(8'h07, 4'(i), 4'(i + 1), 16'(i * 3), 32'(i * 32'h1111));
    endtask

    task automatic load_mixed();
        fill_plain();
        prog[0]  = mk(8'hb7, 4'd1, 4'd0, 16'h0000, 32'hFFFF_FFFB);
        prog[1]  = mk(8'h18, 4'd2, 4'd0, 16'h0000, 32'h89AB_CDEF);
        prog[2]  = mk(8'h00, 4'd0, 4'd0, 16'h0000, 32'h0123_4567);
        prog[3]  = mk(8'h61, 4'd3, 4'd4, 16'h0010, 32'h0);
        prog[4]  = mk(8'h73, 4'd5, 4'd6, 16'hFFF8, 32'h0);
        prog[5]  = mk(8'h84, 4'd7, 4'd0, 16'h0000, 32'h8000_0000);
        prog[6]  = mk(8'hdb, 4'd8, 4'd9, 16'h0020, 32'h1);
        prog[7]  = mk(8'h6b, 4'd1, 4'd2, 16'h0002, 32'h0);
        prog[8]  = mk(8'h95, 4'd0, 4'd0, 16'h0000, 32'h0);
        prog[9]  = mk(8'h30, 4'd0, 4'd0, 16'h0000, 32'h0000_000E);
        prog[10] = mk(8'h81, 4'd3, 4'd1, 16'h0004, 32'h0);
    endtask

    initial begin
        rst_n     = 1'b0;
        out_ready = 1'b0;
        for (int i = 0; i < N; i++) prog[i] = 64'd0;

        // Mixed program ending in a reserved load mode (R6), full throughput.
        load_mixed();
        do_reset();
        run_test(0, "R6");

        // Same program under a stall pattern (R10 hold, R9 ordering).
        do_reset();
        run_test(1, "R6");

        // Wide opcode in the last slot (R7).
        fill_plain();
        prog[N-1] = mk(8'h18, 4'd4, 4'd0, 16'h0, 32'hDEAD_BEEF);
        do_reset();
        run_test(2, "R7");

        // Second half of a pair with a nonzero opcode (R3).
        fill_plain();
        prog[0] = mk(8'h18, 4'd1, 4'd0, 16'h0, 32'h1234_5678);
        prog[1] = mk(8'h07, 4'd1, 4'd0, 16'h0, 32'h9ABC_DEF0);
        do_reset();
        run_test(0, "R3");

        // Legal pair in the last two slots, then run off the end (R8).
        fill_plain();
        prog[N-2] = mk(8'h18, 4'd9, 4'd0, 16'h0, 32'hCAFE_F00D);
        prog[N-1] = mk(8'h00, 4'd0, 4'd0, 16'h0, 32'h8765_4321);
        do_reset();
        run_test(1, "R8");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule